// File: doc/BRIEF.md
# VSYNC-Clocked EDID Serial Transmitter

This block sends EDID bytes to a display host over the open-drain data line, using the monitor's vertical sync as the bit clock. Firmware writes one byte at a time into a single-byte holding buffer. At each frame boundary the block moves the buffered byte into an output shift register. The buffer then counts as empty, and an interrupt request asks firmware for the next byte. A frame lasts nine VSYNC rising edges: eight data bits, most significant first, followed by one released (high) null bit.

The vertical sync input is asynchronous to the system clock. It passes through a two-flop synchroniser, and a rising edge is detected by comparing consecutive synchronised samples. A single request input moves the interface from the VSYNC-clocked mode into the bidirectional mode, which is handled elsewhere. That switch is permanent until reset. It freezes shifting, releases the data line and masks the buffer-empty interrupt.

Top module: `ddc1_edid_tx`

## Requirements
- R1: After reset, `ddc2bMode` is 0, `sdaOut` is 1, and `intReq` is 0 while `intEnable` is 0.
- R2: Only a rising edge of `vsyncIn` advances the output. `sdaOut` changes on the third rising `clk` edge after `vsyncIn` goes high, and it does not change while `vsyncIn` stays high, falls, or stays low.
- R3: One frame takes nine VSYNC rising edges. The first eight put data bits on `sdaOut`, bit 7 first and bit 0 last. The ninth puts a null bit, driven as 1.
- R4: The VSYNC rising edge that follows a null bit, and the first VSYNC rising edge after reset, load the buffered byte into the shift register. That byte's bit 7 appears on `sdaOut` at that edge.
- R5: A load empties the buffer. While `intEnable` is 1, `intReq` is 1 from the load cycle until the next write.
- R6: If no byte was written since the last load, the load sends 0xFF, so `sdaOut` stays 1 for the whole frame.
- R7: While the buffer is empty, `intReq` follows `intEnable` in the same cycle. Because the buffer is empty after reset, enabling the interrupt raises `intReq` at once.
- R8: A `wrEn` cycle stores `wrData`, marks the buffer full, and brings `intReq` to 0 from the next cycle.
- R9: One cycle of `ddc2bReq` sets `ddc2bMode` to 1 from the next cycle until reset. While `ddc2bMode` is 1, `sdaOut` is 1 and `intReq` is 0, and VSYNC edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vsyncIn | input | 1 | Vertical sync used as the serial bit clock, asynchronous |
| wrEn | input | 1 | Processor write strobe for the byte buffer |
| wrData | input | 8 | Byte written into the buffer |
| intEnable | input | 1 | Buffer-empty interrupt enable |
| ddc2bReq | input | 1 | Request to switch to the bidirectional mode |
| sdaOut | output | 1 | Data line level (1 = released) |
| intReq | output | 1 | Buffer-empty interrupt request |
| ddc2bMode | output | 1 | 0 = VSYNC-clocked mode, 1 = bidirectional mode |

## Verification
Each VSYNC-driven result is due three clock edges after `vsyncIn` rises: two edges in the synchroniser and one for the register update. The driver task drives `vsyncIn` at a falling clock edge and counts three rising edges. It then raises a sample event at the next falling edge, where the monitor pops the expected bit and compares it. The driver re-checks the same bit after the pulse has fallen, to confirm it held. `intReq` from `intEnable` is combinational and is checked in the same cycle. Results from `wrEn` and `ddc2bReq` are registered and are checked at the falling edge after the strobe.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;   // frame boundary: take buffered byte
    logic shiftBit;    // advance to next data bit
    logic releaseSda;  // null bit or bidirectional mode
  } ctrlStrobes_t;
endpackage

// File: rtl/ddc1_ctrl.sv
module ddc1_ctrl
  import ddc1_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         vsyncIn,
  input  logic         ddc2bReq,
  input  logic         intEnable,
  input  logic         bufFull,
  output ctrlStrobes_t strobes,
  output logic         intReq,
  output logic         ddc2bMode
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] NULL_IDX = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   vsyncPrev;
  logic                   vsyncRise;
  logic [CNT_W-1:0]       bitCnt;

  // synchroniser stages
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= vsyncIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) vsyncPrev <= 1'b0;
    else       vsyncPrev <= syncChain[SYNC_STAGES-1];

  assign vsyncRise = syncChain[SYNC_STAGES-1] & ~vsyncPrev;

  // mode flag, sticky until reset
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         ddc2bMode <= 1'b0;
    else if (ddc2bReq) ddc2bMode <= 1'b1;

  // bit position; reset to the null slot so the first edge loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= NULL_IDX;
    end else if (vsyncRise && !ddc2bMode) begin
      if (bitCnt == NULL_IDX) bitCnt <= '0;
      else                    bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.loadFrame  = vsyncRise && !ddc2bMode && (bitCnt == NULL_IDX);
    strobes.shiftBit   = vsyncRise && !ddc2bMode && (bitCnt != NULL_IDX);
    strobes.releaseSda = ddc2bMode || (bitCnt == NULL_IDX);
  end

  assign intReq = intEnable & ~bufFull & ~ddc2bMode;
endmodule

// File: rtl/ddc1_datapath.sv
module ddc1_datapath
  import ddc1_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              bufFull,
  output logic              sdaOut
);
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  logic [DATA_W-1:0] holdBuf;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBuf <= IDLE_BYTE;
      bufFull <= 1'b0;
    end else begin
      if (wrEn)                   holdBuf <= wrData;
      if (wrEn)                   bufFull <= 1'b1;
      else if (strobes.loadFrame) bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  shiftReg <= IDLE_BYTE;
    else if (strobes.loadFrame) shiftReg <= bufFull ? holdBuf : IDLE_BYTE;
    else if (strobes.shiftBit)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
  end

  assign sdaOut = strobes.releaseSda | shiftReg[DATA_W-1];
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx
  import ddc1_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vsyncIn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              intEnable,
  input  logic              ddc2bReq,
  output logic              sdaOut,
  output logic              intReq,
  output logic              ddc2bMode
);
  ctrlStrobes_t strobes;
  logic         bufFull;

  ddc1_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .vsyncIn(vsyncIn), .ddc2bReq(ddc2bReq),
    .intEnable(intEnable), .bufFull(bufFull), .strobes(strobes),
    .intReq(intReq), .ddc2bMode(ddc2bMode)
  );

  ddc1_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEn(wrEn),
    .wrData(wrData), .bufFull(bufFull), .sdaOut(sdaOut)
  );
endmodule

// File: rtl/ddc1_edid_tx_chk.sv
module ddc1_edid_tx_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic intEnable,
  input logic ddc2bReq,
  input logic sdaOut,
  input logic intReq,
  input logic ddc2bMode
);
  AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    ddc2bReq |=> ddc2bMode); // R9
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ddc2bMode |=> ddc2bMode); // R9
  AST_MODE_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rstN)
    ddc2bMode |-> sdaOut); // R9
  AST_MODE_MASKS_INT: assert property (@(posedge clk) disable iff (!rstN)
    ddc2bMode |-> !intReq); // R9
  AST_WRITE_CLEARS_INT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !intReq); // R8
  AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intEnable); // R5
endmodule

bind ddc1_edid_tx ddc1_edid_tx_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .intEnable(intEnable),
  .ddc2bReq(ddc2bReq), .sdaOut(sdaOut), .intReq(intReq), .ddc2bMode(ddc2bMode)
);

// File: tb/ddc1_edid_tx_test.sv
module ddc1_edid_tx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vsyncIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       intEnable = 1'b0;
  logic       ddc2bReq = 1'b0;
  logic       sdaOut, intReq, ddc2bMode;

  int   checks = 0;
  int   errors = 0;
  bit   expQ[$];
  event sampleEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc1_edid_tx uut (
    .clk(clk), .rstN(rstN), .vsyncIn(vsyncIn), .wrEn(wrEn), .wrData(wrData),
    .intEnable(intEnable), .ddc2bReq(ddc2bReq), .sdaOut(sdaOut),
    .intReq(intReq), .ddc2bMode(ddc2bMode)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops the expected SDA level when the driver says it is due
  always @(sampleEv) begin
    bit e;
    if (expQ.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3 actual=%0b expected=<empty queue>", sdaOut);
    end else begin
      e = expQ.pop_front();
      check("R3 sda bit", sdaOut, e);
    end
  end

  // one VSYNC pulse carrying an expected SDA level
  task automatic vsyncBit(input bit exp);
    expQ.push_back(exp);
    @(negedge clk) vsyncIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) -> sampleEv;
    repeat (3) @(negedge clk);
    vsyncIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 sda held", sdaOut, exp);
  endtask

  task automatic sendFrame(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) vsyncBit(b[i]);
    vsyncBit(1'b1); // null bit
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk) begin wrEn = 1'b1; wrData = b; end
    @(negedge clk) wrEn = 1'b0;
    check("R8 int cleared", intReq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mode", ddc2bMode, 1'b0);
    check("R1 sda", sdaOut, 1'b1);
    check("R1 int", intReq, 1'b0);

    intEnable = 1'b1; #1;
    check("R7 enable raises int", intReq, 1'b1);

    writeByte(8'hA5);
    // first VSYNC edge loads A5 (R4), then buffer empty -> int (R5)
    vsyncBit(1'b1);
    check("R5 int after load", intReq, 1'b1);
    writeByte(8'h3C);
    for (int i = 6; i >= 0; i--) vsyncBit(8'hA5 >> i);
    vsyncBit(1'b1);
    check("R3 null keeps int low with full buf", intReq, 1'b0);

    sendFrame(8'h3C); // R4 second byte
    check("R5 int after second load", intReq, 1'b1);
    sendFrame(8'hFF); // R6 no write -> idle byte

    writeByte(8'h01);
    vsyncBit(1'b0); // bit 7 of 0x01

    @(negedge clk) ddc2bReq = 1'b1;
    @(negedge clk) ddc2bReq = 1'b0;
    check("R9 mode set", ddc2bMode, 1'b1);
    check("R9 sda released", sdaOut, 1'b1);
    for (int i = 0; i < 10; i++) vsyncBit(1'b1); // R9 edges ignored
    check("R9 int masked", intReq, 1'b0);
    check("R9 mode sticky", ddc2bMode, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule